// File: doc/BRIEF.md
# IrDA SIR Pulse Decoder

This block turns the pulse stream from an infrared receiver into the level signal that a host UART expects. The line from the receiver idles high. A zero bit shows up on it as a short low pulse near the start of the bit period, and a one bit shows up as no pulse at all. The decoder stretches each accepted pulse into a low level that lasts one full bit period on its output, and it drives the output high for bits that carry no pulse.

All timing is counted in ticks of a bit-clock enable that runs at sixteen times the baud rate, so each bit spans sixteen ticks. The receive line first passes through a two-flop synchronizer. A glitch filter then accepts a low run only after it has been sampled low on a set number of consecutive ticks. The first accepted pulse opens a frame of ten bit periods: the start bit, eight data bits and the stop bit. When the frame ends, the decoder goes idle and waits for the next pulse. Because each frame is timed from its own start pulse, the tick rate may change between frames.

Top module: `irda_sir_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `rx_out` is high after that edge and the decoder is idle.
- R2: The decoder changes state only on cycles where `tick_en` is high. Between ticks, `rx_out` holds its value.
- R3: A low run on `rxir_in` that is sampled low on at least MIN_LOW consecutive ticks (default 2) is accepted. This holds once the input has passed the two-flop synchronizer. `rx_out` goes low after the tick that takes the MIN_LOW-th low sample.
- R4: A low run that is shorter than MIN_LOW ticks is ignored, and `rx_out` stays high.
- R5: Each decoded bit lasts exactly 16 ticks on `rx_out`. A bit is low (0) when a pulse is accepted on the tick that begins it, and high (1) otherwise. Data bits follow the start bit least significant bit first.
- R6: A frame lasts 10 bit periods, counted from the tick of the accepted start pulse. After the frame, the decoder is idle with `rx_out` high. A pulse accepted on the exact tick at which the frame ends opens a new frame at once.
- R7: A pulse accepted while `rx_out` is already low for the current bit does not lengthen that bit. This also applies to a single low run that is wider than MIN_LOW.
- R8: A pulse accepted in the middle of a bit whose `rx_out` is high drives `rx_out` low at once. It also restarts that bit period, so the zero lasts 16 ticks and every later bit of the frame moves with it.
- R9: The spacing of `tick_en` pulses may differ from one frame to the next, and each frame is decoded correctly at its own rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Bit-clock enable, 16 pulses per bit period |
| rxir_in | input | 1 | Pulse line from the infrared receiver, idle high, asynchronous |
| rx_out | output | 1 | Registered UART-level output to the host |

## Verification
All 256 byte values are sent as complete frames. The tick spacing alternates between 3 and 4 clocks, and the idle gap between frames is either none or three ticks. Every tick of `rx_out` is compared with the ideal UART waveform, shifted by the acceptance delay. This separates correct bit values and bit order from off-by-one errors in the bit length and the frame length. It also catches errors in the back-to-back start case.

Directed patterns cover the remaining cases:
- A low run one tick short of the minimum, and a pulse of exactly the minimum width, which together pin down the filter threshold.
- A second pulse, and a very wide pulse, inside a bit that is already low, which expose any lengthening of the bit.
- A pulse that arrives late after a high gap, which shows whether the bit period restarts.
- A reset in the middle of a frame.

During the idle clocks between ticks, the bench also checks that `rx_out` does not move.

// File: rtl/irda_rx_pkg.sv
package irda_rx_pkg;
  // bit-clock ticks in one bit period
  parameter int unsigned TICKS_PER_BIT = 16;
  // bit periods in one frame: start, eight data, stop
  parameter int unsigned FRAME_BITS = 10;
  // consecutive low tick samples needed to accept a pulse
  parameter int unsigned MIN_LOW_TICKS = 2;
  // synchronizer depth
  parameter int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    FR_IDLE   = 1'b0,
    FR_ACTIVE = 1'b1
  } frame_state_e;
endpackage

// File: rtl/irda_rx_sync.sv
module irda_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  // each stage resets to the idle (high) level of the line
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= 1'b1;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/irda_rx_glitch_filter.sv
module irda_rx_glitch_filter #(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic line_s,
  output logic pulse_ok
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] RUN_FULL = CW'(MIN_LOW);
  localparam logic [CW-1:0] RUN_LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] run_q;

  // run_q counts low samples so far and saturates, so one low run gives one accept
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (tick_en) begin
      if (line_s)                run_q <= '0;
      else if (run_q != RUN_FULL) run_q <= run_q + CW'(1);
    end
  end

  assign pulse_ok = tick_en && !line_s && (run_q == RUN_LAST);

  // R4
  no_short_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && line_s) |=> !pulse_ok)
    else $error("accept right after a high sample");
endmodule

// File: rtl/irda_rx_framer.sv
module irda_rx_framer
  import irda_rx_pkg::*;
#(
  parameter int unsigned TICKS = 16,
  parameter int unsigned NBITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic pulse_ok,
  output logic rx_o
);
  localparam int unsigned TW = $clog2(TICKS);
  localparam int unsigned BW = $clog2(NBITS);
  localparam logic [TW-1:0] TICK_END = TW'(TICKS - 1);
  localparam logic [BW-1:0] BIT_END  = BW'(NBITS - 1);

  frame_state_e  state_q;
  logic [TW-1:0] tick_q;
  logic [BW-1:0] bit_q;
  logic          rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      rx_q    <= 1'b1;
    end else if (tick_en) begin
      case (state_q)
        FR_IDLE: begin
          if (pulse_ok) begin
            state_q <= FR_ACTIVE;
            tick_q  <= '0;
            bit_q   <= '0;
            rx_q    <= 1'b0;
          end
        end
        default: begin
          if (tick_q == TICK_END) begin
            // this tick begins the next bit period
            tick_q <= '0;
            if (bit_q == BIT_END) begin
              bit_q <= '0;
              if (pulse_ok) begin
                rx_q <= 1'b0;
              end else begin
                state_q <= FR_IDLE;
                rx_q    <= 1'b1;
              end
            end else begin
              bit_q <= bit_q + BW'(1);
              rx_q  <= !pulse_ok;
            end
          end else if (pulse_ok && rx_q) begin
            // late pulse: the bit becomes zero and its period restarts
            rx_q   <= 1'b0;
            tick_q <= '0;
          end else begin
            tick_q <= tick_q + TW'(1);
          end
        end
      endcase
    end
  end

  assign rx_o = rx_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (rx_q && state_q == FR_IDLE))
    else $error("output not high after reset");

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(rx_q) && $stable(tick_q) && $stable(bit_q)))
    else $error("state moved without a tick");

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_IDLE) |-> rx_q)
    else $error("idle with output low");

  // R7
  no_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && state_q == FR_ACTIVE && !rx_q && tick_q != TICK_END) |=> !rx_q)
    else $error("zero bit ended early or was restarted");
endmodule

// File: rtl/irda_sir_decoder.sv
module irda_sir_decoder
  import irda_rx_pkg::*;
#(
  parameter int unsigned TICKS   = TICKS_PER_BIT,
  parameter int unsigned NBITS   = FRAME_BITS,
  parameter int unsigned MIN_LOW = MIN_LOW_TICKS,
  parameter int unsigned STAGES  = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic rxir_in,
  output logic rx_out
);
  logic line_s;
  logic pulse_ok;

  irda_rx_sync #(.STAGES(STAGES)) i_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rxir_in),
    .q_out (line_s)
  );

  irda_rx_glitch_filter #(.MIN_LOW(MIN_LOW)) i_filter (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .line_s   (line_s),
    .pulse_ok (pulse_ok)
  );

  irda_rx_framer #(.TICKS(TICKS), .NBITS(NBITS)) i_framer (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .pulse_ok (pulse_ok),
    .rx_o     (rx_out)
  );

  // R3
  accept_drives_low_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_ok |=> !rx_out)
    else $error("accepted pulse did not give a low output");
endmodule

// File: tb/test_irda_sir_decoder.sv
module test_irda_sir_decoder;
  localparam int MINL = 2;
  localparam int TPB  = 16;
  localparam int NB   = 10;
  localparam int FLEN = TPB * NB;
  localparam int PW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic rxir = 1'b1;
  logic rx_out;
  int   n_checks = 0;
  int   n_fail = 0;
  int   div = 3;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  irda_sir_decoder i_irda_sir_decoder (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .rxir_in (rxir),
    .rx_out  (rx_out)
  );

  task automatic chk(input logic exp, input string tag);
    n_checks++;
    if (rx_out !== exp) begin
      n_fail++;
      $display("FAIL %s: rx_out=%b expected=%b at %0t", tag, rx_out, exp, $time);
    end
  endtask

  // One tick period; starts and ends at a negedge. The tick falls on the last clock.
  task automatic step(input logic x, input logic exp, input string tag);
    logic prev;
    prev = rx_out;
    rxir = x;
    tick_en = 1'b0;
    repeat (div - 1) @(negedge clk);
    chk(prev, "R2 hold between ticks");
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    chk(exp, tag);
  endtask

  function automatic logic fbit(input logic [7:0] data, input int j);
    if (j == 0) return 1'b0;
    if (j == NB - 1) return 1'b1;
    return data[j-1];
  endfunction

  // frame with pulse width pw, idle gap, and an optional extra pulse at extra_at
  task automatic send_frame(input logic [7:0] data, input int pw, input int gap,
                            input int extra_at, input string tag);
    for (int k = 0; k < FLEN + gap; k++) begin
      logic x;
      logic e;
      int   d;
      x = 1'b1;
      if (k < FLEN && fbit(data, k / TPB) == 1'b0 && (k % TPB) < pw) x = 1'b0;
      if (extra_at >= 0 && k >= extra_at && k < extra_at + pw) x = 1'b0;
      d = k - (MINL - 1);
      e = (d >= 0 && d < FLEN) ? fbit(data, d / TPB) : 1'b1;
      step(x, e, tag);
    end
  endtask

  // the second bit's pulse and everything after it arrive late by lag ticks
  task automatic late_frame(input logic [7:0] data, input int lag);
    for (int k = 0; k < FLEN + lag + 2; k++) begin
      logic x;
      logic e;
      int   d;
      int   kk;
      if (k < TPB)            x = (k < PW) ? 1'b0 : 1'b1;
      else if (k < TPB + lag) x = 1'b1;
      else begin
        kk = k - lag;
        x = (kk < FLEN && fbit(data, kk / TPB) == 1'b0 && (kk % TPB) < PW) ? 1'b0 : 1'b1;
      end
      d = k - (MINL - 1);
      if (d < 0)              e = 1'b1;
      else if (d < TPB)       e = 1'b0;
      else if (d < TPB + lag) e = 1'b1;
      else e = (d - lag < FLEN) ? fbit(data, (d - lag) / TPB) : 1'b1;
      step(x, e, "R8 late pulse re-aligns");
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): finished=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds the output high even with a low input and ticks running
    rxir = 1'b0;
    tick_en = 1'b1;
    repeat (6) @(negedge clk);
    chk(1'b1, "R1 output high in reset");
    rxir = 1'b1;
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(1'b1, "R1 output high after reset");

    // R4: a run one tick short of the minimum
    div = 3;
    for (int k = 0; k < MINL - 1; k++) step(1'b0, 1'b1, "R4 short low ignored");
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1, "R4 short low ignored");

    // R3: pulse of exactly the minimum width
    send_frame(8'h5A, MINL, 2, -1, "R3 minimum width accepted");

    // R7: second pulse inside a low bit, and one wide pulse
    send_frame(8'hFF, PW, 2, 6, "R7 second pulse in low bit");
    send_frame(8'h33, 9, 2, -1, "R7 wide pulse not stretched");

    // R8: late pulse after a high gap
    late_frame(8'h6C, 5);

    // R1: reset in the middle of a frame
    for (int k = 0; k < 5; k++) step((k < PW) ? 1'b0 : 1'b1, (k >= MINL - 1) ? 1'b0 : 1'b1,
                                     "R3 start before reset");
    rst = 1'b1;
    @(negedge clk);
    chk(1'b1, "R1 mid-frame reset");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(1'b1, "R1 idle after mid-frame reset");

    // R5 R6 R9: every byte value, rate and gap changing between frames
    for (int v = 0; v < 256; v++) begin
      div = (v % 4 == 3) ? 4 : 3;
      send_frame(v[7:0], PW, (v % 2 == 1) ? 0 : 3, -1, "R5 R6 R9 byte sweep");
    end
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, "R6 idle after last frame");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule